// File: doc/BRIEF.md
# Multi-Mode Memory Test Address Generator

This block supplies the address stream for a memory self-test engine. One binary counter only ever counts up. A small multiplexer in front of each address bit turns the counter value into one of four walk orders: plain linear, address complement (alternating between a value and its inverse), Gray code (one bit changes per step), and single-bit flip. In the flip order, every base address is surrounded by its neighbours at a Hamming distance of one.

No down counter is needed. A descending walk comes from feeding the inverted counter bits into the same per-bit equations. The walk order, the direction and the highest bit index visited by the flip order are captured only while the block is idle. A pass that has started therefore keeps one mode from start to finish. A one-cycle completion pulse marks the moment the base counter wraps back to zero.

The test controller holds `en` low and sets the mode inputs. It then raises `en` and consumes one address per clock until `pass_done` is seen.

Top module: `addr_walk_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `addr` is 0 and `pass_done` is 0. The captured settings reset to linear, upward and flip limit AW-1.
- R2: Mode code 0 (linear) sets `addr` to the counter value C going up (`dir_down`=0) and to ~C going down, so a downward pass walks from 2^AW-1 to 0.
- R3: Mode code 1 (complement) sets address bit AW-1 to B[0] and each lower bit k to B[k+1] XOR B[0], where B is the counter going up. For AW=4 upward this gives 0,15,1,14,2,13,...
- R4: Mode code 2 (Gray) sets the top bit to B[AW-1] and each lower bit k to B[k] XOR B[k+1]. Successive addresses within a pass differ in exactly one bit.
- R5: In the complement, Gray and flip modes, the downward direction applies the same equations with B = ~C.
- R6: Mode code 3 (flip) emits, for each base B and bit index j, three addresses: B with bit j inverted, then B, then B with bit j inverted. No address differs from B in more than one bit. For base 0 and AW=4 the stream begins 1,0,1,2,0,2.
- R7: In flip mode, j steps from 0 up to the captured limit, which is `flip_lim` clamped to AW-1. After the third address for the limit bit, j returns to 0 and the counter advances.
- R8: `pass_done` is high for exactly one cycle: the cycle after the last address of a pass, when the counter has just wrapped from all ones to zero.
- R9: `mode_sel`, `dir_down` and `flip_lim` are captured only on clock edges where `en` is low. Changes to them while `en` is high have no effect on `addr`.
- R10: While `en` is low, the counter and the flip sub-sequencer hold, so `addr` changes only through newly captured settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Advance the walk; when low, settings are captured |
| dir_down | input | 1 | 0 ascending, 1 descending |
| mode_sel | input | 2 | 0 linear, 1 complement, 2 Gray, 3 single-bit flip |
| flip_lim | input | LIMW | Highest bit index visited in flip mode (clamped to AW-1) |
| addr | output | AW | Generated test address |
| pass_done | output | 1 | One-cycle pulse after the last address of a pass |

## Verification
The assertions assume three things. Settings change only through the idle capture. The flip phase never leaves the range 0 to 2. The Gray property applies only to cycles in which `en` is high, because an idle cycle may legitimately load a new mode and jump the address. The stimulus keeps to these limits: every pass starts with an idle cycle that carries the new settings, and `en` is held high for an exact number of cycles so that the counter ends each pass at zero. Mid-pass stalls repeat the same settings, and mode changes made while enabled are used only to test that they are ignored.

// File: rtl/awg_pkg.sv
package awg_pkg;
  typedef enum logic [1:0] {
    WALK_LIN  = 2'd0,
    WALK_CPL  = 2'd1,
    WALK_GRAY = 2'd2,
    WALK_FLIP = 2'd3
  } walk_mode_e;
endpackage

// File: rtl/awg_rst_sync.sv
module awg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/awg_ctl_latch.sv
module awg_ctl_latch
  import awg_pkg::*;
#(
  parameter int AW   = 4,
  parameter int IW   = 2,
  parameter int LIMW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mode_in,
  input  logic            dir_in,
  input  logic [LIMW-1:0] lim_in,
  output walk_mode_e      mode_q,
  output logic            dir_q,
  output logic [IW-1:0]   lim_q
);
  localparam logic [LIMW-1:0] LIM_MAX_W = LIMW'(AW - 1);
  localparam logic [IW-1:0]   LIM_MAX   = IW'(AW - 1);

  walk_mode_e    mode_d;
  logic          dir_d;
  logic [IW-1:0] lim_d;
  logic [IW-1:0] lim_clamped;

  always_comb begin
    if (lim_in > LIM_MAX_W) lim_clamped = LIM_MAX;
    else                    lim_clamped = lim_in[IW-1:0];
  end

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    lim_d  = lim_q;
    if (!en) begin
      mode_d = walk_mode_e'(mode_in);
      dir_d  = dir_in;
      lim_d  = lim_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WALK_LIN;
      dir_q  <= 1'b0;
      lim_q  <= LIM_MAX;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      lim_q  <= lim_d;
    end
  end

  // R9
  settings_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(mode_q) && $stable(dir_q) && $stable(lim_q)));
endmodule

// File: rtl/awg_step_core.sv
module awg_step_core #(
  parameter int AW = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          flip_mode,
  input  logic [IW-1:0] lim,
  output logic [AW-1:0] cnt_q,
  output logic [1:0]    phase_q,
  output logic [IW-1:0] bidx_q,
  output logic          done_q
);
  localparam logic [1:0] LAST_PHASE = 2'd2;

  logic [AW-1:0] cnt_d;
  logic [1:0]    phase_d;
  logic [IW-1:0] bidx_d;
  logic          done_d;
  logic          bump;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    bidx_d  = bidx_q;
    done_d  = 1'b0;
    bump    = 1'b0;
    if (en) begin
      if (!flip_mode) begin
        bump = 1'b1;
      end else if (phase_q != LAST_PHASE) begin
        phase_d = phase_q + 2'd1;
      end else begin
        phase_d = 2'd0;
        if (bidx_q >= lim) begin
          bidx_d = '0;
          bump   = 1'b1;
        end else begin
          bidx_d = bidx_q + IW'(1);
        end
      end
    end
    if (bump) begin
      cnt_d  = cnt_q + AW'(1);
      done_d = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 2'd0;
      bidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      bidx_q  <= bidx_d;
      done_q  <= done_d;
    end
  end

  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(phase_q) && $stable(bidx_q)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == '0));
endmodule

// File: rtl/awg_bit_mux.sv
module awg_bit_mux
  import awg_pkg::*;
#(
  parameter int AW = 4,
  parameter int IW = 2
) (
  input  logic [AW-1:0] cnt,
  input  logic          dir_down,
  input  walk_mode_e    mode,
  input  logic [1:0]    phase,
  input  logic [IW-1:0] bidx,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base;
  logic          flip_active;

  assign base        = dir_down ? ~cnt : cnt;
  assign flip_active = (phase != 2'd1);

  for (genvar k = 0; k < AW; k++) begin : g_bit
    logic cpl_bit;
    logic gray_bit;
    logic flip_bit;

    if (k == AW - 1) begin : g_top
      assign cpl_bit  = base[0];
      assign gray_bit = base[k];
    end else begin : g_low
      assign cpl_bit  = base[k+1] ^ base[0];
      assign gray_bit = base[k] ^ base[k+1];
    end

    assign flip_bit = base[k] ^ (flip_active && (bidx == IW'(k)));

    always_comb begin
      unique case (mode)
        WALK_LIN:  addr[k] = base[k];
        WALK_CPL:  addr[k] = cpl_bit;
        WALK_GRAY: addr[k] = gray_bit;
        WALK_FLIP: addr[k] = flip_bit;
        default:   addr[k] = base[k];
      endcase
    end
  end
endmodule

// File: rtl/addr_walk_gen.sv
module addr_walk_gen
  import awg_pkg::*;
#(
  parameter int AW   = 4,
  parameter int IW   = (AW > 1) ? $clog2(AW) : 1,
  parameter int LIMW = IW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            dir_down,
  input  logic [1:0]      mode_sel,
  input  logic [LIMW-1:0] flip_lim,
  output logic [AW-1:0]   addr,
  output logic            pass_done
);
  logic          rst_sync_n;
  walk_mode_e    mode_q;
  logic          dir_q;
  logic [IW-1:0] lim_q;
  logic [AW-1:0] cnt_q;
  logic [1:0]    phase_q;
  logic [IW-1:0] bidx_q;

  awg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  awg_ctl_latch #(.AW(AW), .IW(IW), .LIMW(LIMW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (en),
    .mode_in (mode_sel),
    .dir_in  (dir_down),
    .lim_in  (flip_lim),
    .mode_q  (mode_q),
    .dir_q   (dir_q),
    .lim_q   (lim_q)
  );

  awg_step_core #(.AW(AW), .IW(IW)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .flip_mode (mode_q == WALK_FLIP),
    .lim       (lim_q),
    .cnt_q     (cnt_q),
    .phase_q   (phase_q),
    .bidx_q    (bidx_q),
    .done_q    (pass_done)
  );

  awg_bit_mux #(.AW(AW), .IW(IW)) u_mux (
    .cnt      (cnt_q),
    .dir_down (dir_q),
    .mode     (mode_q),
    .phase    (phase_q),
    .bidx     (bidx_q),
    .addr     (addr)
  );

  // R4
  gray_one_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && mode_q == WALK_GRAY) |=> ($countones(addr ^ $past(addr)) == 1));

  // R6
  flip_distance_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == WALK_FLIP) |->
      ($countones(addr ^ (dir_q ? ~cnt_q : cnt_q)) == ((phase_q == 2'd1) ? 0 : 1)));

  // R1
  reset_addr_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (addr == '0 && !pass_done));
endmodule

// File: tb/addr_walk_gen_tb.sv
module addr_walk_gen_tb;
  localparam int AW   = 4;
  localparam int IW   = 2;
  localparam int LIMW = 3;
  localparam logic [AW-1:0] ALL1 = '1;

  logic            clk;
  logic            rst_n;
  logic            en;
  logic            dir_down;
  logic [1:0]      mode_sel;
  logic [LIMW-1:0] flip_lim;
  logic [AW-1:0]   addr;
  logic            pass_done;

  int total = 0;
  int bad   = 0;

  logic [AW-1:0] q_addr[$];
  logic          q_done[$];
  string         q_tag[$];

  logic [AW-1:0] m_cnt;
  logic [1:0]    m_phase;
  int            m_bidx;
  logic [1:0]    m_mode;
  logic          m_dir;
  int            m_lim;
  logic          m_done;

  addr_walk_gen #(.AW(AW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .dir_down  (dir_down),
    .mode_sel  (mode_sel),
    .flip_lim  (flip_lim),
    .addr      (addr),
    .pass_done (pass_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] c, input logic d,
                                             input logic [1:0] m, input logic [1:0] ph,
                                             input int j);
    logic [AW-1:0] b;
    logic [AW-1:0] r;
    b = d ? ~c : c;
    r = b;
    case (m)
      2'd1: begin
        r[AW-1] = b[0];
        for (int k = 0; k < AW - 1; k++) r[k] = b[k+1] ^ b[0];
      end
      2'd2: begin
        r[AW-1] = b[AW-1];
        for (int k = 0; k < AW - 1; k++) r[k] = b[k] ^ b[k+1];
      end
      2'd3: if (ph != 2'd1) r[j] = ~b[j];
      default: r = b;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit e, input logic [1:0] m, input bit d, input int lim,
                      input string tag);
    @(negedge clk);
    en = e; mode_sel = m; dir_down = d; flip_lim = LIMW'(lim);
    m_done = 1'b0;
    if (!e) begin
      m_mode = m; m_dir = d; m_lim = (lim > AW - 1) ? AW - 1 : lim;
    end else begin
      bit bump;
      bump = 1'b0;
      if (m_mode != 2'd3) bump = 1'b1;
      else if (m_phase != 2'd2) m_phase = m_phase + 2'd1;
      else begin
        m_phase = 2'd0;
        if (m_bidx >= m_lim) begin m_bidx = 0; bump = 1'b1; end
        else m_bidx = m_bidx + 1;
      end
      if (bump) begin
        m_done = (m_cnt == ALL1);
        m_cnt  = m_cnt + AW'(1);
      end
    end
    q_addr.push_back(exp_addr(m_cnt, m_dir, m_mode, m_phase, m_bidx));
    q_done.push_back(m_done);
    q_tag.push_back(tag);
  endtask

  task automatic peek(input logic [AW-1:0] e, input string tag);
    @(posedge clk); #6;
    check(addr == e, tag, addr, e);
  endtask

  task automatic run_pass(input logic [1:0] m, input bit d, input int lim, input int n,
                          input string tag);
    step(0, m, d, lim, tag);
    for (int i = 0; i < n; i++) step(1, m, d, lim, tag);
  endtask

  // monitor: pops one expected item per clock
  initial begin
    logic [AW-1:0] prev;
    bit prev_gray;
    prev_gray = 1'b0;
    prev = '0;
    forever begin
      @(posedge clk); #5;
      if (q_addr.size() > 0) begin
        logic [AW-1:0] ea;
        logic ed;
        string t;
        ea = q_addr.pop_front();
        ed = q_done.pop_front();
        t  = q_tag.pop_front();
        check(addr == ea, {t, " addr"}, addr, ea);
        check(pass_done == ed, {t, " pass_done R8"}, pass_done, ed);
        if (t == "R4" && prev_gray)
          check($countones(addr ^ prev) == 1, "R4 one-bit step", $countones(addr ^ prev), 1);
        prev_gray = (t == "R4") && en;
        prev = addr;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; dir_down = 1'b0; mode_sel = 2'd0; flip_lim = LIMW'(AW - 1);
    m_cnt = '0; m_phase = 2'd0; m_bidx = 0; m_mode = 2'd0; m_dir = 1'b0; m_lim = AW - 1;
    m_done = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check(addr == '0, "R1 addr in reset", addr, 0);
    check(pass_done == 1'b0, "R1 done in reset", pass_done, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 2'd0, 1'b0, AW - 1, "R1");

    // R2 linear up and down, R8 done
    run_pass(2'd0, 1'b0, 0, 16, "R2");
    run_pass(2'd0, 1'b1, 0, 16, "R2");

    // R3 complement literal start, then rest of pass
    step(0, 2'd1, 1'b0, 0, "R3");
    peek(4'd0, "R3 step0");
    step(1, 2'd1, 1'b0, 0, "R3"); peek(4'd15, "R3 step1");
    step(1, 2'd1, 1'b0, 0, "R3"); peek(4'd1,  "R3 step2");
    step(1, 2'd1, 1'b0, 0, "R3"); peek(4'd14, "R3 step3");
    step(1, 2'd1, 1'b0, 0, "R3"); peek(4'd2,  "R3 step4");
    step(1, 2'd1, 1'b0, 0, "R3"); peek(4'd13, "R3 step5");
    for (int i = 0; i < 11; i++) step(1, 2'd1, 1'b0, 0, "R3");

    // R5 complement down, Gray up/down
    run_pass(2'd1, 1'b1, 0, 16, "R5");
    run_pass(2'd2, 1'b0, 0, 16, "R4");
    run_pass(2'd2, 1'b1, 0, 16, "R4");

    // R6 flip literal start for base 0
    step(0, 2'd3, 1'b0, 3, "R6");
    peek(4'd1, "R6 t0");
    step(1, 2'd3, 1'b0, 3, "R6"); peek(4'd0, "R6 t1");
    step(1, 2'd3, 1'b0, 3, "R6"); peek(4'd1, "R6 t2");
    step(1, 2'd3, 1'b0, 3, "R6"); peek(4'd2, "R6 t3");
    step(1, 2'd3, 1'b0, 3, "R6"); peek(4'd0, "R6 t4");
    step(1, 2'd3, 1'b0, 3, "R6"); peek(4'd2, "R6 t5");
    for (int i = 0; i < 16 * 4 * 3 - 5; i++) step(1, 2'd3, 1'b0, 3, "R6");

    // R7 reduced limit, downward (R5), then clamped limit
    run_pass(2'd3, 1'b1, 1, 16 * 2 * 3, "R7");
    run_pass(2'd3, 1'b0, 7, 16 * 4 * 3, "R7");

    // R9 settings changed while enabled are ignored
    step(0, 2'd0, 1'b0, 0, "R9");
    for (int i = 0; i < 16; i++) step(1, 2'((i % 3) + 1), 1'(i % 2), 1, "R9");

    // R10 stall mid-pass holds the address
    step(0, 2'd2, 1'b0, 0, "R10");
    for (int i = 0; i < 5; i++) step(1, 2'd2, 1'b0, 0, "R10");
    for (int i = 0; i < 3; i++) step(0, 2'd2, 1'b0, 0, "R10");
    for (int i = 0; i < 11; i++) step(1, 2'd2, 1'b0, 0, "R10");

    step(0, 2'd0, 1'b0, 0, "R10");
    @(posedge clk); #8;
    @(posedge clk); #8;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule